// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of a two-wire station management link. It produces the management clock and shifts out complete frames on the data line so that software can reach registers inside an attached PHY. Software sees four 32-bit word registers: a configuration word (clock divider, frame type, preamble), a command word (opcode, PHY address, register or device address), a transmit-data word and a receive-data word. Writing the command word starts exactly one frame.

Two frame flavours exist. In the short-address flavour a frame is a complete read or write. In the extended-address flavour a register access takes two frames: first an address frame whose data field carries the 16-bit register number, then a read or write frame whose register-address field names the device. The master releases the data line from the turnaround onward in a read frame, checks that the PHY pulls the line low in the second turnaround bit, and captures 16 data bits.

Top module: `mdio_master`

## Requirements
- R1: After reset the management clock and the output enable are low, both pending flags and the read-valid flag are clear, and the clock stays low with the line released whenever no frame is in progress.
- R2: A command written with the frame-type bit (config bit 16) at 0 sends start bits 01, then opcode bits 01 for command opcode 0 (write) or 10 for command opcode 1 (read), then the 5-bit PHY address (command bits 12:8) and the 5-bit register address (command bits 20:16), both MSB first; command opcode occupies bits 1:0.
- R3: With the frame-type bit at 1 the start bits are 00 and command opcodes 0, 1 and 3 send opcode bits 00 (address), 01 (write) and 11 (read); the register-address field then carries the device address.
- R4: With the preamble bit (config bit 17) set, a frame is 64 MDC periods long and opens with 32 ones; with it clear, a frame is 32 periods long.
- R5: In write and address frames the master drives every bit, sends turnaround 10, and sends transmit-data bits 15:0 MSB first as the data field.
- R6: In read frames the output enable is high through the register-address field and low from the first turnaround bit to the end; the 16 bits sampled on MDC rising edges appear MSB first in receive-data bits 15:0 once the frame ends.
- R7: The read-valid flag (receive-data bit 30) is cleared when a read frame starts and is set at its end only if the line was low at the rising MDC edge of the second turnaround bit.
- R8: The transmit pending flag (transmit-data bit 31) is set from the launch of a write or address frame until it ends; the receive pending flag (receive-data bit 31) does the same for read frames.
- R9: MDC is high for N+1 and low for N+1 system clocks, where N is config bits 15:0 latched at launch; the data line changes only when MDC falls. Read capture needs N at least the input-synchronizer depth.
- R10: A command written while either pending flag is set is dropped and does not start a frame afterwards.
- R11: Command opcodes 2 and 3 in the short-address flavour and opcode 2 in the extended flavour start no frame and leave the pending flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write word select: 0 config, 1 command, 2 transmit data, 3 receive data |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Read word select, same encoding |
| reg_rdata | output | 32 | Selected register value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A wrong bit counter or shift register shows up on the data line within one MDC period: the captured frame length or a field bit differs from the value built from the command, and the pending flag clears early or late. A bad divider shows as a wrong MDC high time on the first rising edge of a frame. A fault in turnaround checking or read capture surfaces only when the frame ends, as a wrong valid flag or data word in the receive register, and a broken busy guard shows as extra MDC edges after the frame the bench expected to be the last.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [1:0] {
      SEL_CFG  = 2'd0,
      SEL_CMD  = 2'd1,
      SEL_WDAT = 2'd2,
      SEL_RDAT = 2'd3
   } mdio_sel_e;

   // Field order is the order of transmission, MSB first
   typedef struct packed {
      logic [1:0]  start;
      logic [1:0]  opc;
      logic [4:0]  phy;
      logic [4:0]  regad;
      logic [1:0]  ta;
      logic [15:0] data;
   } mdio_frame_t;

   typedef struct packed {
      logic       legal;
      logic       rd;
      logic [1:0] code;
   } mdio_opdec_t;

   function automatic mdio_opdec_t decode_op(input logic ext, input logic [1:0] op);
      mdio_opdec_t d;
      d = '0;
      if (ext) begin
         case (op)
            2'd0:    d = '{legal: 1'b1, rd: 1'b0, code: 2'b00};
            2'd1:    d = '{legal: 1'b1, rd: 1'b0, code: 2'b01};
            2'd3:    d = '{legal: 1'b1, rd: 1'b1, code: 2'b11};
            default: d = '0;
         endcase
      end else begin
         case (op)
            2'd0:    d = '{legal: 1'b1, rd: 1'b0, code: 2'b01};
            2'd1:    d = '{legal: 1'b1, rd: 1'b1, code: 2'b10};
            default: d = '0;
         endcase
      end
      return d;
   endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] hcnt;
   logic             tick;

   assign tick = run && (hcnt == half_div);
   assign rise = tick && !mdc;
   assign fall = tick && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         mdc  <= 1'b0;
      end else if (!run) begin
         hcnt <= '0;
         mdc  <= 1'b0;
      end else if (tick) begin
         hcnt <= '0;
         mdc  <= ~mdc;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
   import mdio_pkg::*;
#(
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  mdio_frame_t frame,
   input  logic        pre_en,
   input  logic        is_read,
   input  logic        rise,
   input  logic        fall,
   input  logic        mdio_i,
   output logic        busy,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        done,
   output logic [15:0] rx_data,
   output logic        ta_ok
);
   localparam int FW     = $bits(mdio_frame_t);
   localparam int SW     = PRE_LEN + FW;
   localparam int CW     = $clog2(SW + 1);
   localparam int TA_POS = FW - 16 - 2;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..3");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be positive");
   end

   logic [SW-1:0] sh;
   logic [CW-1:0] cnt, last, off, fpos;
   logic          rd_q, din, in_frame;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign din = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ff <= '1;
         end else begin
            ff[0] <= mdio_i;
            for (int i = 1; i < SYNC_STAGES; i++) ff[i] <= ff[i-1];
         end
      end
      assign din = ff[SYNC_STAGES-1];
   end

   assign in_frame = (cnt >= off);
   assign fpos     = cnt - off;
   assign mdio_oe  = busy && !(rd_q && in_frame && (fpos >= CW'(TA_POS)));
   assign mdio_o   = busy && sh[SW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         cnt     <= '0;
         last    <= '0;
         off     <= '0;
         rd_q    <= 1'b0;
         busy    <= 1'b0;
         done    <= 1'b0;
         rx_data <= '0;
         ta_ok   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            sh    <= pre_en ? {{PRE_LEN{1'b1}}, frame} : {frame, {PRE_LEN{1'b0}}};
            cnt   <= '0;
            last  <= pre_en ? CW'(SW - 1) : CW'(FW - 1);
            off   <= pre_en ? CW'(PRE_LEN) : '0;
            rd_q  <= is_read;
            busy  <= 1'b1;
            ta_ok <= 1'b0;
         end else if (busy) begin
            if (rise && rd_q && in_frame) begin
               if (fpos == CW'(TA_POS + 1)) ta_ok <= !din;
               if (fpos >= CW'(TA_POS + 2)) rx_data <= {rx_data[14:0], din};
            end
            if (fall) begin
               if (cnt == last) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
                  sh  <= {sh[SW-2:0], 1'b0};
               end
            end
         end
      end
   end

   // Once a read frame lets go of the line it keeps it released to the end
   assert_oe_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mdio_oe |=> !mdio_oe || !busy);

   // The line only moves on a falling MDC edge within a frame
   assert_mdio_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !$past(fall) |-> $stable(mdio_o));

   // No launch request reaches the engine while a frame is in flight
   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [1:0]  reg_waddr,
   input  logic [31:0] reg_wdata,
   input  logic [1:0]  reg_raddr,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("DIV_W must lie in 1..16");
   end

   logic [DIV_W-1:0] cfg_div, div_q;
   logic             cfg_ext, cfg_pre;
   logic [15:0]      wdat, rdat, eng_rx;
   logic             rd_valid, wr_pend, rd_pend;
   logic             cmd_we, launch;
   logic             eng_busy, eng_done, eng_ta_ok, tick_r, tick_f;
   mdio_opdec_t      dec;
   mdio_frame_t      frm;
   logic             unused_wd;

   assign unused_wd = ^reg_wdata[31:21];
   assign cmd_we    = reg_we && (reg_waddr == SEL_CMD);
   assign dec       = decode_op(cfg_ext, reg_wdata[1:0]);
   assign launch    = cmd_we && dec.legal && !wr_pend && !rd_pend;

   always_comb begin
      frm.start = cfg_ext ? 2'b00 : 2'b01;
      frm.opc   = dec.code;
      frm.phy   = reg_wdata[12:8];
      frm.regad = reg_wdata[20:16];
      frm.ta    = dec.rd ? 2'b11 : 2'b10;
      frm.data  = dec.rd ? 16'hFFFF : wdat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_div  <= '0;
         cfg_ext  <= 1'b0;
         cfg_pre  <= 1'b0;
         div_q    <= '0;
         wdat     <= '0;
         rdat     <= '0;
         rd_valid <= 1'b0;
         wr_pend  <= 1'b0;
         rd_pend  <= 1'b0;
      end else begin
         if (reg_we && reg_waddr == SEL_CFG) begin
            cfg_div <= reg_wdata[DIV_W-1:0];
            cfg_ext <= reg_wdata[16];
            cfg_pre <= reg_wdata[17];
         end
         if (reg_we && reg_waddr == SEL_WDAT) wdat <= reg_wdata[15:0];
         if (launch) begin
            div_q   <= cfg_div;
            wr_pend <= !dec.rd;
            rd_pend <= dec.rd;
            if (dec.rd) rd_valid <= 1'b0;
         end else if (eng_done) begin
            if (rd_pend) begin
               rdat     <= eng_rx;
               rd_valid <= eng_ta_ok;
            end
            wr_pend <= 1'b0;
            rd_pend <= 1'b0;
         end
      end
   end

   always_comb begin
      case (mdio_sel_e'(reg_raddr))
         SEL_CFG:  reg_rdata = {14'd0, cfg_pre, cfg_ext, 16'(cfg_div)};
         SEL_CMD:  reg_rdata = '0;
         SEL_WDAT: reg_rdata = {wr_pend, 15'd0, wdat};
         default:  reg_rdata = {rd_pend, rd_valid, 14'd0, rdat};
      endcase
   end

   mdio_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (eng_busy),
      .half_div (div_q),
      .mdc      (mdc),
      .rise     (tick_r),
      .fall     (tick_f)
   );

   mdio_shift_engine #(.PRE_LEN(PRE_LEN), .SYNC_STAGES(SYNC_STAGES)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (launch),
      .frame   (frm),
      .pre_en  (cfg_pre),
      .is_read (dec.rd),
      .rise    (tick_r),
      .fall    (tick_f),
      .mdio_i  (mdio_i),
      .busy    (eng_busy),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .done    (eng_done),
      .rx_data (eng_rx),
      .ta_ok   (eng_ta_ok)
   );

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !mdc && !mdio_oe);

   assert_pend_covers_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> wr_pend || rd_pend);

   assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> !wr_pend && !rd_pend);

   assert_valid_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $past(eng_done) && $past(eng_ta_ok));

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #5 clk = ~clk;

   mdio_master dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   int          cap_n = 0;
   logic        cap_bit [0:127];
   logic        cap_oe  [0:127];
   time         t_rise = 0;
   time         hi_time = 0;
   int          phy_pre = 0;
   logic        phy_ta2 = 1'b0;
   logic [15:0] phy_resp = '0;

   // PHY-side monitor: capture on rising MDC, answer after falling MDC
   always @(posedge mdc) begin
      if (cap_n < 128) begin
         cap_bit[cap_n] = mdio_o;
         cap_oe[cap_n]  = mdio_oe;
      end
      cap_n  = cap_n + 1;
      t_rise = $time;
   end

   always @(negedge mdc) begin : phy_drive
      int fp;
      hi_time = $time - t_rise;
      fp = cap_n - phy_pre;
      if (fp == 14)                mdio_i = 1'b1;
      else if (fp == 15)           mdio_i = phy_ta2;
      else if (fp >= 16 && fp < 32) mdio_i = phy_resp[31-fp];
      else                         mdio_i = 1'b1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_raddr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] w, r;
      for (int i = 0; i < 20000; i++) begin
         reg_read(2'd2, w);
         reg_read(2'd3, r);
         if (!w[31] && !r[31]) break;
      end
   endtask

   function automatic logic [1:0] op_bits(input logic ext, input logic [1:0] op);
      if (ext) return (op == 2'd0) ? 2'b00 : (op == 2'd1) ? 2'b01 : 2'b11;
      return (op == 2'd0) ? 2'b01 : 2'b10;
   endfunction

   function automatic logic [31:0] cmd_word(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] rg);
      return {11'd0, rg, 3'd0, phy, 6'd0, op};
   endfunction

   // Launch one frame and compare what appeared on the line
   task automatic run_frame(input logic ext, input logic pre, input int div,
                            input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] rg, input logic [15:0] wd,
                            input logic rd, input string req);
      logic [31:0] exp_f, v;
      int          n, bad_b, bad_o, first;
      logic        eb, eo;
      reg_write(2'd0, {14'd0, pre, ext, 16'(div)});
      reg_write(2'd2, {16'd0, wd});
      cap_n   = 0;
      phy_pre = pre ? 32 : 0;
      reg_write(2'd1, cmd_word(op, phy, rg));
      reg_read(rd ? 2'd3 : 2'd2, v);
      check(v[31] == 1'b1, "R8", "pending after launch", v[31], 1);
      wait_idle();
      n = pre ? 64 : 32;
      check(cap_n == n, "R4", "frame length", cap_n, n);
      exp_f = {ext ? 2'b00 : 2'b01, op_bits(ext, op), phy, rg,
               rd ? 2'b11 : 2'b10, rd ? 16'd0 : wd};
      bad_b = 0; bad_o = 0; first = -1;
      for (int i = 0; i < n && i < 128; i++) begin
         int fp;
         fp = i - phy_pre;
         eb = (fp < 0) ? 1'b1 : exp_f[31-fp];
         eo = !(rd && fp >= 14);
         if (cap_oe[i] !== eo) bad_o++;
         if (eo && cap_bit[i] !== eb) begin
            bad_b++;
            if (first < 0) first = i;
         end
      end
      check(bad_b == 0, req, "frame bits (mismatch count)", bad_b, 0);
      check(bad_o == 0, rd ? "R6" : "R5", "output enable pattern (mismatch count)", bad_o, 0);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      reg_read(2'd3, v);
      check(v == 32'd0, "R1", "receive word after reset", v, 0);
      reg_read(2'd2, v);
      check(v[31] == 1'b0, "R1", "transmit pending after reset", v[31], 0);
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "mdc/oe after reset", {mdc, mdio_oe}, 0);
   endtask

   task automatic t_short_write();
      logic [31:0] v;
      run_frame(1'b0, 1'b1, 3, 2'd0, 5'h05, 5'h1A, 16'hC0DE, 1'b0, "R2");
      check(hi_time == 40, "R9", "MDC high time ns", hi_time, 40);
      reg_read(2'd2, v);
      check(v[31] == 1'b0, "R8", "transmit pending after frame", v[31], 0);
      check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "idle after frame", {mdc, mdio_oe}, 0);
   endtask

   task automatic t_short_read();
      logic [31:0] v;
      phy_ta2 = 1'b0; phy_resp = 16'hA5C3;
      run_frame(1'b0, 1'b0, 2, 2'd1, 5'h1F, 5'h01, 16'h0000, 1'b1, "R2");
      check(hi_time == 30, "R9", "MDC high time ns", hi_time, 30);
      reg_read(2'd3, v);
      check(v == 32'h4000A5C3, "R6", "receive word", v, 32'h4000A5C3);
   endtask

   task automatic t_ext_sequence();
      logic [31:0] v;
      run_frame(1'b1, 1'b1, 2, 2'd0, 5'h11, 5'h03, 16'h1234, 1'b0, "R3");
      run_frame(1'b1, 1'b1, 2, 2'd1, 5'h11, 5'h03, 16'hBEEF, 1'b0, "R3");
      phy_ta2 = 1'b0; phy_resp = 16'h5A0F;
      run_frame(1'b1, 1'b1, 2, 2'd3, 5'h11, 5'h03, 16'h0000, 1'b1, "R3");
      reg_read(2'd3, v);
      check(v == 32'h40005A0F, "R6", "extended read word", v, 32'h40005A0F);
   endtask

   task automatic t_ta_fail();
      logic [31:0] v;
      reg_read(2'd3, v);
      check(v[30] == 1'b1, "R7", "valid before failing read", v[30], 1);
      phy_ta2 = 1'b1; phy_resp = 16'h1111;
      reg_write(2'd0, {14'd0, 1'b0, 1'b0, 16'd2});
      cap_n = 0; phy_pre = 0;
      reg_write(2'd1, cmd_word(2'd1, 5'h02, 5'h04));
      reg_read(2'd3, v);
      check(v[30] == 1'b0, "R7", "valid cleared at read launch", v[30], 0);
      wait_idle();
      reg_read(2'd3, v);
      check(v[30] == 1'b0, "R7", "valid after bad turnaround", v[30], 0);
      phy_ta2 = 1'b0;
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      reg_write(2'd0, {14'd0, 1'b1, 1'b0, 16'd3});
      reg_write(2'd2, 32'h0000_7E57);
      cap_n = 0; phy_pre = 32;
      reg_write(2'd1, cmd_word(2'd0, 5'h01, 5'h02));
      repeat (30) @(negedge clk);
      reg_write(2'd1, cmd_word(2'd1, 5'h01, 5'h02));
      reg_read(2'd3, v);
      check(v[31] == 1'b0, "R10", "read pending after dropped command", v[31], 0);
      wait_idle();
      repeat (300) @(negedge clk);
      check(cap_n == 64, "R10", "MDC rising edges after dropped command", cap_n, 64);
   endtask

   task automatic t_illegal();
      logic [31:0] w, r;
      reg_write(2'd0, {14'd0, 1'b0, 1'b0, 16'd1});
      cap_n = 0;
      reg_write(2'd1, cmd_word(2'd2, 5'h03, 5'h03));
      reg_write(2'd1, cmd_word(2'd3, 5'h03, 5'h03));
      reg_write(2'd0, {14'd0, 1'b0, 1'b1, 16'd1});
      reg_write(2'd1, cmd_word(2'd2, 5'h03, 5'h03));
      reg_read(2'd2, w);
      reg_read(2'd3, r);
      check(!w[31] && !r[31], "R11", "pending flags after undefined opcodes", {w[31], r[31]}, 0);
      repeat (100) @(negedge clk);
      check(cap_n == 0, "R11", "MDC edges after undefined opcodes", cap_n, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_short_write();
      t_short_read();
      t_ext_sequence();
      t_ta_fail();
      t_busy_ignore();
      t_illegal();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule